// File: doc/BRIEF.md
# Four-Level Radix Page Table Walker

This block turns a 48-bit virtual address into a physical address. It walks a four-level radix page table in memory, one dependent read per level. A request is taken together with the current root table pointer. The walker then steps down from the most significant 9-bit index to the least significant one. At each level it reads one 8-byte entry through a valid/ready read port and waits for the response. Each valid entry supplies the frame of the next table. The last entry supplies the frame of the page itself, and the 12-bit page offset is appended unchanged.

If any entry read has its valid flag clear, the walk stops at once. It returns a one-cycle fault pulse that carries the number of the level that failed. Only one walk runs at a time. A busy output holds off the requester until the response cycle is over. The physical address width is a parameter, meant for the 40 to 50 bit range.

Top module: `ptw_walker`

## Requirements
- R1: For level L (L = 0 for the first read, 3 for the last), the index is `req_vaddr[47-9L -: 9]`. The entry read address is the table base plus index × 8. The level-0 base is the `root_ptr` value sampled in the cycle the request is accepted.
- R2: After a valid entry at level 0, 1 or 2, the next table base is the entry's frame field, bits [PA_W-1:12], shifted left by 12. Entry bits above PA_W-1 and bits 11:1 have no effect.
- R3: Entry bit 0 is the valid flag. A read entry with bit 0 = 0 at level L gives a one-cycle `fault` pulse with `fault_level` = L, and no further memory read is made for that walk.
- R4: When all four entries are valid, a one-cycle `done` pulse is given with `paddr` = {last entry bits [PA_W-1:12], `req_vaddr[11:0]`}.
- R5: A request is accepted at a rising edge where `req_valid` = 1 and `busy` = 0. `busy` is 1 from the next cycle up to and including the cycle of the `done` or `fault` pulse, and 0 in the cycle after it.
- R6: A request presented while `busy` = 1 is ignored. It produces no response and no read, and it does not change the walk in progress.
- R7: `mem_req_valid` stays high with a constant `mem_req_addr` until `mem_req_ready` is seen. Exactly one read is made per level visited, and the next level's read starts only after `mem_rsp_valid` has returned the previous entry.
- R8: Changes to `root_ptr` after a request is accepted do not affect that walk.
- R9: While reset is applied, `busy`, `mem_req_valid`, `done` and `fault` are 0.
- R10: `done` and `fault` never rise together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 48 | Virtual address to translate |
| root_ptr | input | PA_W | Physical base of the level-0 table |
| busy | output | 1 | Walk in progress; requests are not accepted |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | PA_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle pulse: translation complete |
| fault | output | 1 | One-cycle pulse: invalid entry found |
| fault_level | output | 2 | Level of the invalid entry (0 to 3) |
| paddr | output | PA_W | Translated physical address, valid with done |

## Verification
The hardest case to reach from the ports is a walk where back-pressure and response delay vary from level to level. Every read must stay pending without its address moving, and a fault deep in the table must stop the read stream exactly there. The bench memory model draws ready stalls and response delays from a shift-register sequence. It builds trees that share upper-level tables and plants invalid entries at each of the four levels. It also counts the reads made in each walk. Separate walks apply a new request or change the root pointer while a walk is under way, to show that neither reaches the walk in flight.

// File: rtl/ptw_pkg.sv
// Package: shared state encoding for the page table walker.
// Assumes nothing beyond the walker's own modules importing it.
package ptw_pkg;
    typedef enum logic [2:0] {
        WS_IDLE,
        WS_READ,
        WS_WAIT,
        WS_DONE,
        WS_FAULT
    } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
// Entry address former: picks the index field for the current level and
// adds index * entry size to the current table base.
// Assumes the index field list is packed with level 0 in the top bits.
module ptw_addr_gen #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int PA_W   = 44,
    parameter int PTE_SH = 3,
    parameter int LVL_W  = 2
) (
    input  logic [LEVELS*IDX_W-1:0] idx_field,
    input  logic [LVL_W-1:0]        level,
    input  logic [PA_W-1:0]         base,
    output logic [PA_W-1:0]         entry_addr
);
    logic [IDX_W-1:0] idx_arr [LEVELS];
    logic [IDX_W-1:0] idx_sel;

    // one slice per level, most significant slice for level 0
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_arr[g] = idx_field[(LEVELS-g)*IDX_W-1 -: IDX_W];
    end

    // select the slice of the current level
    assign idx_sel = idx_arr[level];

    // base plus scaled index
    assign entry_addr = base + {{(PA_W-IDX_W-PTE_SH){1'b0}}, idx_sel, {PTE_SH{1'b0}}};
endmodule

// File: rtl/ptw_pte_decode.sv
// Entry decoder: extracts the valid flag and the frame-aligned base from a
// returned table entry. Assumes PTE_W > PA_W and the frame field in [PA_W-1:OFF_W].
module ptw_pte_decode #(
    parameter int PTE_W = 64,
    parameter int PA_W  = 44,
    parameter int OFF_W = 12
) (
    input  logic [PTE_W-1:0] entry,
    output logic             pte_valid,
    output logic [PA_W-1:0]  pte_base
);
    logic unused_pte_bits;

    // flag and frame base
    assign pte_valid = entry[0];
    assign pte_base  = {entry[PA_W-1:OFF_W], {OFF_W{1'b0}}};

    // bits without meaning to the walker
    assign unused_pte_bits = ^{entry[PTE_W-1:PA_W], entry[OFF_W-1:1]};
endmodule

// File: rtl/ptw_ctrl.sv
// Walk sequencer: accepts one request at a time, steps the level and table
// base on each valid entry, and ends with a done or fault pulse.
// Assumes the read response arrives no earlier than the cycle after the
// request handshake.
module ptw_ctrl
    import ptw_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 44,
    parameter int LVL_W  = 2,
    parameter int VA_W   = LEVELS*IDX_W + OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [VA_W-1:0]         req_vaddr,
    input  logic [PA_W-1:0]         root_ptr,
    input  logic                    mem_req_ready,
    input  logic                    mem_rsp_valid,
    input  logic                    pte_valid,
    input  logic [PA_W-1:0]         pte_base,
    output logic                    busy,
    output logic                    mem_req_valid,
    output logic [LVL_W-1:0]        level,
    output logic [PA_W-1:0]         base,
    output logic [LEVELS*IDX_W-1:0] idx_field,
    output logic                    done,
    output logic                    fault,
    output logic [LVL_W-1:0]        fault_level,
    output logic [PA_W-1:0]         paddr
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS-1);

    walk_state_e      state_q;
    logic [LVL_W-1:0] level_q;
    logic [PA_W-1:0]  base_q;
    logic [VA_W-1:0]  vaddr_q;
    logic [PA_W-1:0]  paddr_q;
    logic [LVL_W-1:0] flevel_q;

    // walk state, level, base and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WS_IDLE;
            level_q  <= '0;
            base_q   <= '0;
            vaddr_q  <= '0;
            paddr_q  <= '0;
            flevel_q <= '0;
        end else begin
            case (state_q)
                WS_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        base_q  <= root_ptr;
                        level_q <= '0;
                        state_q <= WS_READ;
                    end
                end
                WS_READ: begin
                    if (mem_req_ready) begin
                        state_q <= WS_WAIT;
                    end
                end
                WS_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!pte_valid) begin
                            flevel_q <= level_q;
                            state_q  <= WS_FAULT;
                        end else if (level_q == LAST_LVL) begin
                            paddr_q <= {pte_base[PA_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
                            state_q <= WS_DONE;
                        end else begin
                            base_q  <= pte_base;
                            level_q <= level_q + LVL_W'(1);
                            state_q <= WS_READ;
                        end
                    end
                end
                WS_DONE:  state_q <= WS_IDLE;
                WS_FAULT: state_q <= WS_IDLE;
                default:  state_q <= WS_IDLE;
            endcase
        end
    end

    // decoded outputs
    assign busy          = (state_q != WS_IDLE);
    assign mem_req_valid = (state_q == WS_READ);
    assign done          = (state_q == WS_DONE);
    assign fault         = (state_q == WS_FAULT);
    assign level         = level_q;
    assign base          = base_q;
    assign idx_field     = vaddr_q[VA_W-1:OFF_W];
    assign fault_level   = flevel_q;
    assign paddr         = paddr_q;

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R5
    AST_BUSY_COVERS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> busy); // R5
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !(done || fault)); // R10
    AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)); // R10
    AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy); // R7
    AST_VADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !fault) |=> $stable(vaddr_q)); // R6
endmodule

// File: rtl/ptw_walker.sv
// Top of the page table walker: ties the sequencer to the entry address
// former and the entry decoder. Assumes a single outstanding memory read.
module ptw_walker #(
    parameter int PA_W      = 44,
    parameter int LEVELS    = 4,
    parameter int IDX_W     = 9,
    parameter int OFF_W     = 12,
    parameter int PTE_BYTES = 8,
    localparam int VA_W     = LEVELS*IDX_W + OFF_W,
    localparam int PTE_W    = PTE_BYTES*8,
    localparam int PTE_SH   = $clog2(PTE_BYTES),
    localparam int LVL_W    = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  root_ptr,
    output logic             busy,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             done,
    output logic             fault,
    output logic [LVL_W-1:0] fault_level,
    output logic [PA_W-1:0]  paddr
);
    logic [LVL_W-1:0]        level;
    logic [PA_W-1:0]         base;
    logic [LEVELS*IDX_W-1:0] idx_field;
    logic                    pte_valid;
    logic [PA_W-1:0]         pte_base;

    // sequencer
    ptw_ctrl #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .LVL_W(LVL_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .root_ptr(root_ptr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .pte_valid(pte_valid), .pte_base(pte_base),
        .busy(busy), .mem_req_valid(mem_req_valid),
        .level(level), .base(base), .idx_field(idx_field),
        .done(done), .fault(fault), .fault_level(fault_level), .paddr(paddr)
    );

    // entry address for the current level
    ptw_addr_gen #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .PA_W(PA_W), .PTE_SH(PTE_SH), .LVL_W(LVL_W)
    ) addr_i (
        .idx_field(idx_field), .level(level), .base(base), .entry_addr(mem_req_addr)
    );

    // returned entry decode
    ptw_pte_decode #(
        .PTE_W(PTE_W), .PA_W(PA_W), .OFF_W(OFF_W)
    ) dec_i (
        .entry(mem_rsp_data), .pte_valid(pte_valid), .pte_base(pte_base)
    );

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7
endmodule

// File: tb/ptw_walker_tb_top.sv
// Scoreboard bench: the driver computes each expected result from the
// table contents and queues it; the monitor compares every response.
module ptw_walker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PA_W = 44;

    typedef struct {
        bit              flt;
        int              lvl;
        logic [PA_W-1:0] pa;
        int              nreads;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [47:0]     req_vaddr = '0;
    logic [PA_W-1:0] root_ptr = '0;
    logic            busy, mem_req_valid, done, fault;
    logic            mem_req_ready = 1'b0;
    logic [PA_W-1:0] mem_req_addr, paddr;
    logic            mem_rsp_valid = 1'b0;
    logic [63:0]     mem_rsp_data = '0;
    logic [1:0]      fault_level;

    int checks = 0;
    int failures = 0;
    int total_reads = 0;
    int start_reads = 0;
    int stall_mode = 0;
    exp_t sbq[$];

    logic [63:0]     mem [logic [PA_W-1:0]];
    logic [PA_W-1:0] next_tbl = 44'h000_0200_0000;

    ptw_walker #(.PA_W(PA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .root_ptr(root_ptr), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .fault_level(fault_level), .paddr(paddr)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] rd(input logic [PA_W-1:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    function automatic logic [47:0] mkva(input int i0, i1, i2, i3, input logic [11:0] off);
        return {9'(i0), 9'(i1), 9'(i2), 9'(i3), off};
    endfunction

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // reference walk built from R1 to R4
    function automatic exp_t ref_walk(input logic [47:0] va, input logic [PA_W-1:0] root, input string tag);
        exp_t r;
        logic [PA_W-1:0] b = root;
        logic [63:0] e;
        r.tag = tag; r.flt = 0; r.lvl = 0; r.pa = '0;
        for (int l = 0; l < 4; l++) begin
            logic [8:0] ix = va[47-9*l -: 9];
            e = rd(b + {ix, 3'b000});
            r.nreads = l + 1;
            if (!e[0]) begin
                r.flt = 1; r.lvl = l;
                return r;
            end
            b = {e[PA_W-1:12], 12'h000};
        end
        r.pa = {b[PA_W-1:12], va[11:0]};
        return r;
    endfunction

    // build the path for va; break_lvl >= 0 plants an invalid entry there
    task automatic map_va(input logic [PA_W-1:0] root, input logic [47:0] va,
                          input logic [PA_W-1:0] frame, input int break_lvl);
        logic [PA_W-1:0] b = root;
        for (int l = 0; l < 4; l++) begin
            logic [PA_W-1:0] ea = b + {va[47-9*l -: 9], 3'b000};
            logic [63:0] e;
            if (l == break_lvl) begin
                mem[ea] = 64'h8000_0ABC_DEF0_10FE;
                return;
            end
            if (l < 3) begin
                e = rd(ea);
                if (!e[0]) begin
                    mem[ea] = 64'(next_tbl) | 64'h8000_0000_0000_0021;
                    b = next_tbl;
                    next_tbl = next_tbl + 44'h1000;
                end else begin
                    b = {e[PA_W-1:12], 12'h000};
                end
            end else begin
                mem[ea] = 64'({frame[PA_W-1:12], 12'h000}) | 64'hC000_0000_0000_0FE1;
            end
        end
    endtask

    // memory model with varied ready stalls and response delays
    initial begin : mem_model
        bit pending = 0;
        int rsp_wait = 0;
        logic [PA_W-1:0] pend_addr = '0;
        logic [15:0] lfsr = 16'hACE1;
        forever begin
            @(posedge clk);
            if (rst_n && mem_req_valid && mem_req_ready) begin
                pending = 1;
                pend_addr = mem_req_addr;
                rsp_wait = (stall_mode != 0) ? int'(lfsr[3:2]) : 0;
                total_reads++;
            end
            @(negedge clk);
            mem_rsp_valid = 0;
            mem_rsp_data = 64'hDEAD_BEEF_0BAD_F00D;
            if (pending) begin
                if (rsp_wait == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data = rd(pend_addr);
                    pending = 0;
                end else begin
                    rsp_wait--;
                end
            end
            mem_req_ready = mem_req_valid && !pending && (stall_mode == 0 || lfsr[0]);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
    end

    // monitor: pops expected items and compares responses
    initial begin : monitor
        bit chk_next = 0;
        exp_t x;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (chk_next) begin
                    check(!busy && !done && !fault, "R5 busy low after response", {busy, done, fault}, 0);
                    chk_next = 0;
                end
                if (done || fault) begin
                    check(!(done && fault), "R10 done and fault together", {done, fault}, 0);
                    check(busy, "R5 busy during response", busy, 1);
                    if (sbq.size() == 0) begin
                        check(0, "R6 response with no queued request", {done, fault}, 0);
                    end else begin
                        x = sbq.pop_front();
                        check(fault == x.flt, {x.tag, " R3 fault flag"}, fault, x.flt);
                        if (x.flt) begin
                            check(int'(fault_level) == x.lvl, {x.tag, " R3 fault level"}, fault_level, x.lvl);
                        end else begin
                            check(paddr == x.pa, {x.tag, " R4 physical address"}, paddr, x.pa);
                        end
                        check(total_reads - start_reads == x.nreads, {x.tag, " R7 read count"},
                              total_reads - start_reads, x.nreads);
                    end
                    chk_next = 1;
                end
            end
        end
    end

    // driver: queue the expectation and present one request
    task automatic walk(input logic [47:0] va, input logic [PA_W-1:0] root, input string tag,
                        input bit swap_root, input bit extra_req);
        while (busy) @(negedge clk);
        sbq.push_back(ref_walk(va, root, tag));
        start_reads = total_reads;
        req_valid = 1; req_vaddr = va; root_ptr = root;
        @(negedge clk);
        req_valid = 0;
        if (swap_root) root_ptr = 44'h7FF_FFFF_F000;
        if (extra_req) begin
            req_valid = 1; req_vaddr = ~va;
            repeat (3) @(negedge clk);
            req_valid = 0;
        end
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R7 watchdog: walk never completed");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam logic [PA_W-1:0] ROOT_A = 44'h000_0010_0000;
    localparam logic [PA_W-1:0] ROOT_B = 44'h000_0800_0000;

    initial begin : stimulus
        map_va(ROOT_A, mkva(0, 0, 0, 0, 12'h000), 44'h123_4567_8000, -1);
        map_va(ROOT_A, mkva(511, 511, 511, 511, 12'hFFF), 44'hFED_CBA9_8000, -1);
        map_va(ROOT_A, mkva(5, 300, 1, 77, 12'h000), 44'h0AB_0000_1000, -1);
        map_va(ROOT_A, mkva(5, 300, 1, 78, 12'h000), 44'h0CD_0000_2000, -1);
        map_va(ROOT_A, mkva(101, 7, 7, 7, 12'h000), 44'h111_0000_0000, 1);
        map_va(ROOT_A, mkva(102, 8, 9, 10, 12'h000), 44'h222_0000_0000, 2);
        map_va(ROOT_A, mkva(103, 1, 2, 3, 12'h000), 44'h333_0000_0000, 3);
        map_va(ROOT_B, mkva(0, 0, 0, 0, 12'h000), 44'h555_5555_5000, -1);

        repeat (3) @(negedge clk);
        check(!busy, "R9 busy in reset", busy, 0);
        check(!mem_req_valid, "R9 read request in reset", mem_req_valid, 0);
        check(!done, "R9 done in reset", done, 0);
        check(!fault, "R9 fault in reset", fault, 0);
        rst_n = 1;
        @(negedge clk);

        for (int pass = 0; pass < 2; pass++) begin
            stall_mode = pass;
            walk(mkva(0, 0, 0, 0, 12'h000), ROOT_A, "R1 R2 index zero", 0, 0);
            walk(mkva(511, 511, 511, 511, 12'hFFF), ROOT_A, "R1 R2 index max offset max", 0, 0);
            walk(mkva(5, 300, 1, 77, 12'h5A5), ROOT_A, "R1 R2 mixed", 0, 0);
            walk(mkva(5, 300, 1, 78, 12'h001), ROOT_A, "R1 R2 shared prefix", 0, 0);
            walk(mkva(100, 0, 0, 0, 12'h010), ROOT_A, "R3 level0", 0, 0);
            walk(mkva(101, 7, 7, 7, 12'h020), ROOT_A, "R3 level1", 0, 0);
            walk(mkva(102, 8, 9, 10, 12'h030), ROOT_A, "R3 level2", 0, 0);
            walk(mkva(103, 1, 2, 3, 12'h040), ROOT_A, "R3 level3", 0, 0);
            walk(mkva(0, 0, 0, 0, 12'h3C3), ROOT_B, "R8 root changed mid-walk", 1, 0);
            walk(mkva(5, 300, 1, 77, 12'h777), ROOT_A, "R6 request while busy", 0, 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule